// File: doc/BRIEF.md
# LCD refresh DMA and serializer

This block keeps a monochrome dot-matrix panel refreshed from a frame buffer held in system memory. A free-running period timer wakes it at a fixed interval. It then requests the memory bus, and once the CPU grants it, it reads the bytes that make up one display row. It releases the bus and streams the row to a pair of external column-driver chips, two bits per falling edge of a shift clock. A strobe pulse then tells the drivers to latch the row. When the strobe falls, the block updates its row-select index and the three panel columns that it drives itself.

The panel is 64 lines high. Each line carries 128 bits for the column drivers and three further columns driven directly by this block. For each row the block therefore fetches sixteen driver bytes and one extra byte, and takes the three direct columns from that extra byte. Successive rows are read from consecutive addresses. The fetch pointer reloads from the base-address input whenever row 0 is about to be fetched, so software can move the frame buffer between frames.

Top module: `lcd_refresh_dma`

## Requirements
- R1: While reset is active the outputs read bus_req=0, mem_rd=0, shift_clk=1, line_strobe=0, ld_data=0, row_idx=0 and direct_cols=0.
- R2: bus_req rises exactly PERIOD clock cycles after its previous rise. It stays high until all LINE_BITS/8+1 bytes of the row have returned, and falls one cycle after the last byte comes back.
- R3: mem_rd is asserted only in cycles where bus_grant and bus_req are both high. A withdrawn grant pauses the burst and does not lose or repeat a byte. Read data is taken from mem_rdata in the cycle after mem_rd.
- R4: Within a burst, each read address is one above the previous read address. The address wraps at the top of the AW-bit space.
- R5: Each row sends LINE_BITS/2 bit pairs on ld_data, one per falling edge of shift_clk. The first fetched byte goes first, most significant bit first, and ld_data[1] carries the earlier bit of each pair.
- R6: During a row transfer shift_clk stays high for DIV cycles and then low for DIV cycles for every pair. It stays high at all other times, including during the fetch and the strobe.
- R7: After the last pair, line_strobe is high for DIV cycles. On the cycle it falls, row_idx takes the index of the row just sent. The row index counts 0 to ROWS-1 and wraps to 0, and row_idx changes at no other time.
- R8: direct_cols takes bits [7:5] of the last byte fetched for the row on the cycle line_strobe falls, and holds that value until the next fall.
- R9: The first read of a burst for row 0 uses the current base_addr. The burst for any other row continues one address past the previous burst, whatever value base_addr has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | AW | Frame buffer start address, sampled before each row-0 burst |
| bus_req | output | 1 | Memory bus request to the arbiter |
| bus_grant | input | 1 | Memory bus grant from the arbiter |
| mem_rd | output | 1 | Read strobe, one byte per cycle |
| mem_addr | output | AW | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| ld_data | output | 2 | Serial pixel pair to the column drivers |
| shift_clk | output | 1 | Shift clock; drivers sample on its falling edge |
| line_strobe | output | 1 | Row latch pulse; its falling edge starts a new line |
| row_idx | output | $clog2(ROWS) | Index of the row currently latched |
| direct_cols | output | 3 | The three directly driven panel columns |

## Verification
The bench builds the block with ROWS=4, LINE_BITS=16, DIV=2, PERIOD=120 and AW=16. Each row is then a three-byte burst followed by eight shift pairs, and the row counter wraps after four strobes. Every stimulus vector runs six rows, which covers the wrap back to row 0 and the base reload. A base change made in the middle of a frame is shown to be ignored until row 0. The vectors also delay the grant, withdraw it in the middle of a burst, and start the frame buffer near the top of the 16-bit address space so that the address wraps inside a burst.

// File: rtl/lcd_refresh_pkg.sv
`timescale 1ns/1ps
package lcd_refresh_pkg;
  // serializer phases
  typedef enum logic [1:0] {
    SER_IDLE   = 2'd0,
    SER_SHIFT  = 2'd1,
    SER_STROBE = 2'd2
  } ser_state_e;
endpackage

// File: rtl/lcd_period_timer.sv
`timescale 1ns/1ps
module lcd_period_timer #(
  parameter int PERIOD = 12200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(PERIOD - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lcd_row_fetch.sv
`timescale 1ns/1ps
module lcd_row_fetch #(
  parameter int AW        = 20,
  parameter int LINE_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 reload,
  input  logic [AW-1:0]        base,
  input  logic                 grant,
  input  logic [7:0]           rdata,
  output logic                 bus_req,
  output logic                 mem_rd,
  output logic [AW-1:0]        mem_addr,
  output logic [LINE_BITS-1:0] line,
  output logic [7:0]           tail,
  output logic                 done
);
  localparam int BYTES = LINE_BITS / 8 + 1;
  localparam int CW    = $clog2(BYTES + 1);

  logic                 active_q, active_d;
  logic                 rvalid_q;
  logic [CW-1:0]        issue_q, issue_d;
  logic [CW-1:0]        recv_q, recv_d;
  logic [AW-1:0]        ptr_q, ptr_d;
  logic [LINE_BITS-1:0] line_q, line_d;
  logic [7:0]           tail_q, tail_d;
  logic                 last_beat;

  assign mem_rd    = active_q && grant && (issue_q != CW'(BYTES));
  assign last_beat = rvalid_q && (recv_q == CW'(BYTES - 1));
  assign bus_req   = active_q;
  assign mem_addr  = ptr_q;
  assign line      = line_q;
  assign tail      = tail_q;
  assign done      = last_beat;

  always_comb begin
    active_d = active_q;
    issue_d  = issue_q;
    recv_d   = recv_q;
    ptr_d    = ptr_q;
    line_d   = line_q;
    tail_d   = tail_q;
    if (start) begin
      active_d = 1'b1;
      issue_d  = '0;
      recv_d   = '0;
      if (reload) ptr_d = base;
    end
    if (mem_rd) begin
      ptr_d   = ptr_q + 1'b1;
      issue_d = issue_q + 1'b1;
    end
    if (rvalid_q) begin
      recv_d = recv_q + 1'b1;
      if (last_beat) begin
        tail_d   = rdata;
        active_d = 1'b0;
      end else begin
        line_d = {line_q[LINE_BITS-9:0], rdata};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rvalid_q <= 1'b0;
      issue_q  <= '0;
      recv_q   <= '0;
      ptr_q    <= '0;
    end else begin
      active_q <= active_d;
      rvalid_q <= mem_rd;
      issue_q  <= issue_d;
      recv_q   <= recv_d;
      ptr_q    <= ptr_d;
    end
  end

  // data registers only move on a returning byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      tail_q <= '0;
    end else if (rvalid_q) begin
      line_q <= line_d;
      tail_q <= tail_d;
    end
  end
endmodule

// File: rtl/lcd_line_serializer.sv
`timescale 1ns/1ps
module lcd_line_serializer
  import lcd_refresh_pkg::*;
#(
  parameter int LINE_BITS = 128,
  parameter int DIV       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [LINE_BITS-1:0] line,
  output logic [1:0]           ld_data,
  output logic                 shift_clk,
  output logic                 line_strobe,
  output logic                 done
);
  localparam int PAIRS = LINE_BITS / 2;
  localparam int PW    = $clog2(PAIRS);
  localparam int DW    = $clog2(DIV + 1);

  ser_state_e           state_q, state_d;
  logic [LINE_BITS-1:0] sreg_q, sreg_d;
  logic [PW-1:0]        pair_q, pair_d;
  logic [DW-1:0]        div_q, div_d;
  logic                 phase_q, phase_d;
  logic                 div_end;

  assign div_end     = (div_q == DW'(DIV - 1));
  assign shift_clk   = !((state_q == SER_SHIFT) && phase_q);
  assign ld_data     = (state_q == SER_SHIFT) ? sreg_q[LINE_BITS-1 -: 2] : 2'b00;
  assign line_strobe = (state_q == SER_STROBE);
  assign done        = (state_q == SER_STROBE) && div_end;

  always_comb begin
    state_d = state_q;
    sreg_d  = sreg_q;
    pair_d  = pair_q;
    div_d   = div_q;
    phase_d = phase_q;
    case (state_q)
      SER_IDLE: begin
        if (load) begin
          state_d = SER_SHIFT;
          sreg_d  = line;
          pair_d  = '0;
          div_d   = '0;
          phase_d = 1'b0;
        end
      end
      SER_SHIFT: begin
        if (div_end) begin
          div_d = '0;
          if (!phase_q) begin
            phase_d = 1'b1;
          end else begin
            phase_d = 1'b0;
            sreg_d  = {sreg_q[LINE_BITS-3:0], 2'b00};
            if (pair_q == PW'(PAIRS - 1)) state_d = SER_STROBE;
            else                          pair_d  = pair_q + 1'b1;
          end
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      SER_STROBE: begin
        if (div_end) begin
          div_d   = '0;
          state_d = SER_IDLE;
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      default: state_d = SER_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      sreg_q  <= '0;
      pair_q  <= '0;
      div_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sreg_q  <= sreg_d;
      pair_q  <= pair_d;
      div_q   <= div_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/lcd_refresh_dma.sv
`timescale 1ns/1ps
module lcd_refresh_dma #(
  parameter int AW        = 20,
  parameter int LINE_BITS = 128,
  parameter int ROWS      = 64,
  parameter int DIV       = 4,
  parameter int PERIOD    = 12200
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           base_addr,
  output logic                    bus_req,
  input  logic                    bus_grant,
  output logic                    mem_rd,
  output logic [AW-1:0]           mem_addr,
  input  logic [7:0]              mem_rdata,
  output logic [1:0]              ld_data,
  output logic                    shift_clk,
  output logic                    line_strobe,
  output logic [$clog2(ROWS)-1:0] row_idx,
  output logic [2:0]              direct_cols
);
  localparam int RW = $clog2(ROWS);

  logic                 tick, start, fetch_done, ser_done;
  logic                 busy_q, busy_d;
  logic [RW-1:0]        row_q, row_d;
  logic [RW-1:0]        shown_q, shown_d;
  logic [2:0]           dcols_q, dcols_d;
  logic [LINE_BITS-1:0] line;
  logic [7:0]           tail;

  // a tick that arrives while a row is still in flight is dropped
  assign start = tick && !busy_q;

  lcd_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk (clk), .rst_n (rst_n), .tick (tick)
  );

  lcd_row_fetch #(.AW(AW), .LINE_BITS(LINE_BITS)) u_fetch (
    .clk (clk), .rst_n (rst_n), .start (start), .reload (row_q == '0),
    .base (base_addr), .grant (bus_grant), .rdata (mem_rdata),
    .bus_req (bus_req), .mem_rd (mem_rd), .mem_addr (mem_addr),
    .line (line), .tail (tail), .done (fetch_done)
  );

  lcd_line_serializer #(.LINE_BITS(LINE_BITS), .DIV(DIV)) u_ser (
    .clk (clk), .rst_n (rst_n), .load (fetch_done), .line (line),
    .ld_data (ld_data), .shift_clk (shift_clk),
    .line_strobe (line_strobe), .done (ser_done)
  );

  always_comb begin
    busy_d  = busy_q;
    row_d   = row_q;
    shown_d = shown_q;
    dcols_d = dcols_q;
    if (start) busy_d = 1'b1;
    if (ser_done) begin
      busy_d  = 1'b0;
      shown_d = row_q;
      dcols_d = tail[7:5];
      row_d   = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      row_q   <= '0;
      shown_q <= '0;
      dcols_q <= '0;
    end else begin
      busy_q  <= busy_d;
      row_q   <= row_d;
      shown_q <= shown_d;
      dcols_q <= dcols_d;
    end
  end

  assign row_idx     = shown_q;
  assign direct_cols = dcols_q;
endmodule

// File: rtl/lcd_refresh_dma_chk.sv
`timescale 1ns/1ps
module lcd_refresh_dma_chk #(
  parameter int AW   = 20,
  parameter int ROWS = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_req,
  input logic                    bus_grant,
  input logic                    mem_rd,
  input logic [AW-1:0]           mem_addr,
  input logic                    shift_clk,
  input logic                    line_strobe,
  input logic [$clog2(ROWS)-1:0] row_idx,
  input logic [2:0]              direct_cols
);
  AST_RD_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (bus_grant && bus_req)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(1))); // R4
  AST_CLK_HIGH_OUTSIDE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || line_strobe) |-> shift_clk); // R6
  AST_NO_STROBE_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !line_strobe); // R7
  AST_ROW_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(line_strobe) |-> $stable(row_idx)); // R7
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(row_idx) < ROWS); // R7
  AST_COLS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(line_strobe) |-> $stable(direct_cols)); // R8
endmodule

bind lcd_refresh_dma lcd_refresh_dma_chk #(.AW(AW), .ROWS(ROWS)) u_chk (
  .clk (clk), .rst_n (rst_n), .bus_req (bus_req), .bus_grant (bus_grant),
  .mem_rd (mem_rd), .mem_addr (mem_addr), .shift_clk (shift_clk),
  .line_strobe (line_strobe), .row_idx (row_idx), .direct_cols (direct_cols)
);

// File: tb/lcd_refresh_dma_tb.sv
`timescale 1ns/1ps
module lcd_refresh_dma_tb;
  localparam int AW     = 16;
  localparam int LB     = 16;
  localparam int ROWS   = 4;
  localparam int DIV    = 2;
  localparam int PERIOD = 120;
  localparam int BYTES  = LB / 8 + 1;
  localparam int PAIRS  = LB / 2;
  localparam int RW     = $clog2(ROWS);
  localparam int WD     = 100000;
  localparam int NVEC   = 3;
  // {base[15:0], grant delay[3:0], mid-burst grant drop}
  localparam logic [20:0] VEC [NVEC] = '{
    {16'h0100, 4'd0, 1'b0},
    {16'h7FF0, 4'd3, 1'b1},
    {16'hFFFE, 4'd1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          bus_req, mem_rd, shift_clk, line_strobe;
  logic          bus_grant = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = '0;
  logic [1:0]    ld_data;
  logic [RW-1:0] row_idx;
  logic [2:0]    direct_cols;

  int   cur_gdly = 0;
  bit   cur_hold = 1'b0;
  int   gcnt = 0;

  always #10 clk = ~clk;

  lcd_refresh_dma #(.AW(AW), .LINE_BITS(LB), .ROWS(ROWS), .DIV(DIV), .PERIOD(PERIOD)) u_dut (
    .clk (clk), .rst_n (rst_n), .base_addr (base_addr), .bus_req (bus_req),
    .bus_grant (bus_grant), .mem_rd (mem_rd), .mem_addr (mem_addr),
    .mem_rdata (mem_rdata), .ld_data (ld_data), .shift_clk (shift_clk),
    .line_strobe (line_strobe), .row_idx (row_idx), .direct_cols (direct_cols)
  );

  function automatic logic [7:0] mem_fn(input logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) mem_rdata <= mem_fn(mem_addr);

  // arbiter model: delayed grant, optional two-cycle withdrawal
  always @(posedge clk) begin
    if (!bus_req) begin
      gcnt      <= 0;
      bus_grant <= 1'b0;
    end else begin
      gcnt      <= gcnt + 1;
      bus_grant <= (gcnt + 1 >= cur_gdly) &&
                   !(cur_hold && ((gcnt + 1 == cur_gdly + 2) || (gcnt + 1 == cur_gdly + 3)));
    end
  end

  // ---------------- monitor: all checks live here ----------------
  int n_checks = 0, n_fail = 0, rows_done = 0, cyc = 0;
  bit wd_fired = 1'b0, rst_checked = 1'b0;
  bit p_req, p_clk, p_str, rise_seen;
  logic [2:0] p_dcols;
  int since_rise, nb, np, run, st_run, aerr, gerr, cerr, derr;
  logic [RW-1:0] exp_row;
  logic [AW-1:0] exp_addr, first_exp, first_got;
  logic [7:0]    ebytes [BYTES];
  logic [LB-1:0] bits, eline;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD && !wd_fired) begin
      wd_fired = 1'b1;
      chk(1'b0, "watchdog expired", cyc, WD);
    end
    if (!rst_n) begin
      if (!rst_checked) begin
        chk(!bus_req && !mem_rd, "R1 reset bus signals", {bus_req, mem_rd}, 0);
        chk(shift_clk && !line_strobe && ld_data == 2'b00, "R1 reset serial outputs",
            {shift_clk, line_strobe, ld_data}, 4'b1000);
        chk(row_idx == '0 && direct_cols == '0, "R1 reset row and columns",
            {row_idx, direct_cols}, 0);
        rst_checked = 1'b1;
      end
      p_req = 0; p_clk = 1; p_str = 0; p_dcols = '0; rise_seen = 0;
      since_rise = 0; nb = 0; np = 0; run = 0; st_run = 0;
      aerr = 0; gerr = 0; cerr = 0; derr = 0;
      exp_row = '0; exp_addr = '0; bits = '0; rows_done = 0;
    end else begin
      rst_checked = 1'b0;
      since_rise++;
      if (bus_req && !p_req) begin
        if (rise_seen) chk(since_rise == PERIOD, "R2 request period", since_rise, PERIOD);
        rise_seen  = 1'b1;
        since_rise = 0;
        first_exp  = (exp_row == '0) ? base_addr : exp_addr;
        exp_addr   = first_exp;
        nb         = 0;
      end
      if (mem_rd) begin
        if (!bus_grant) gerr++;
        if (mem_addr != exp_addr) aerr++;
        if (nb == 0) first_got = mem_addr;
        if (nb < BYTES) ebytes[nb] = mem_fn(exp_addr);
        exp_addr = exp_addr + 1'b1;
        nb++;
      end
      if (!bus_req && p_req) chk(nb == BYTES, "R2 bytes per burst", nb, BYTES);
      if (shift_clk != p_clk) begin
        if (!shift_clk) begin
          bits = {bits[LB-3:0], ld_data};
          np++;
          if (np > 1 && run != DIV) cerr++;
        end else if (run != DIV) begin
          cerr++;
        end
        run = 1;
      end else begin
        run++;
      end
      if (!(p_str && !line_strobe) && direct_cols != p_dcols) derr++;
      if (line_strobe) st_run++;
      if (p_str && !line_strobe) begin
        eline = '0;
        for (int i = 0; i < BYTES - 1; i++) eline = {eline[LB-9:0], ebytes[i]};
        chk(bits == eline && np == PAIRS, "R5 serial line data", bits, eline);
        chk(row_idx == exp_row, "R7 row index at strobe fall", row_idx, exp_row);
        chk(st_run == DIV, "R7 strobe width", st_run, DIV);
        chk(direct_cols == ebytes[BYTES-1][7:5], "R8 direct columns",
            direct_cols, ebytes[BYTES-1][7:5]);
        chk(derr == 0, "R8 direct columns held", derr, 0);
        chk(aerr == 0, "R4 consecutive addresses", aerr, 0);
        chk(gerr == 0, "R3 reads only under grant", gerr, 0);
        chk(cerr == 0, "R6 shift clock phases", cerr, 0);
        chk(first_got == first_exp, "R9 burst start address", first_got, first_exp);
        exp_row = (exp_row == RW'(ROWS - 1)) ? '0 : exp_row + 1'b1;
        np = 0; bits = '0; st_run = 0; aerr = 0; gerr = 0; cerr = 0; derr = 0;
        rows_done++;
      end
      p_req = bus_req; p_clk = shift_clk; p_str = line_strobe; p_dcols = direct_cols;
    end
  end

  // ---------------- stimulus: vector table, then wrap/base corner ----------------
  initial begin
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk); #2;
      rst_n     = 1'b0;
      base_addr = VEC[v][20:5];
      cur_gdly  = int'(VEC[v][4:1]);
      cur_hold  = VEC[v][0];
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      while (rows_done < 2 && !wd_fired) @(negedge clk);
      // R9: a new base mid-frame is only picked up at the next row 0
      #2 base_addr = base_addr ^ 16'h0400;
      while (rows_done < ROWS + 2 && !wd_fired) @(negedge clk);
      if (wd_fired) break;
    end
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule